// File: doc/BRIEF.md
# Barrel Shifter with Carry

A purely combinational word shifter meant to sit in front of an ALU as its second-operand stage. It takes a data word, a three-bit shift kind, a shift count and an incoming carry flag. It returns the shifted word together with the carry that the shift produces.

Five kinds are supported: left shift with zero fill, right shift with zero fill, right shift that copies the sign bit, word rotation to the right, and a one-position rotation through the carry flag. For every kind that moves bits out of the word, the outgoing carry is the last bit to leave. A zero count leaves both the word and the carry untouched.

All right shifts are built from one log-depth funnel. Left shifts reuse that funnel by reversing the bit order of the word on the way in and on the way out. A separate bit picker selects the outgoing carry, so the carry never depends on the funnel's result path.

Top module: `barrel_shift_carry`

## Requirements
- R1: With kind code 0 (left shift) and a count n from 1 to 31, the result is the operand moved up by n with zeros in the low n bits, and the carry out is operand bit 32-n.
- R2: With kind code 1 (logical right shift) and a count n from 1 to 31, the result is the operand moved down by n with zeros in the high n bits, and the carry out is operand bit n-1.
- R3: With kind code 2 (arithmetic right shift) and a count n from 1 to 31, the result is the operand moved down by n with copies of operand bit 31 in the high n bits, and the carry out is operand bit n-1.
- R4: With kind code 3 (rotate right) and a count n from 1 to 31, the bits leaving bit 0 re-enter at bit 31, and the carry out equals result bit 31.
- R5: With kind code 4 (rotate through carry), the result is the carry in placed above operand bits 31..1, and the carry out is operand bit 0, whatever the count input holds.
- R6: For kind codes 0 to 3 with a count of 0, the result equals the operand and the carry out equals the carry in.
- R7: With a count of 32, kind 0 gives zero with carry out equal to operand bit 0. Kind 1 gives zero, and kind 2 gives 32 copies of operand bit 31; both give carry out equal to operand bit 31. Kind 3 gives back the operand with carry out equal to operand bit 31.
- R8: For kind codes 0 to 3, any count from 33 to 63 gives the same result and carry out as a count of 32.
- R9: For kind codes 5, 6 and 7, the result equals the operand and the carry out equals the carry in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_operand | input | DATA_W (32) | Word to be shifted |
| i_kind | input | 3 | Shift kind: 0 left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 rotate through carry |
| i_amount | input | $clog2(DATA_W)+1 (6) | Shift count; ignored for kind 4 |
| i_carry | input | 1 | Incoming carry flag |
| o_result | output | DATA_W (32) | Shifted word |
| o_carry | output | 1 | Last bit shifted out, or the carry in when nothing moves |

## Verification
The assertions are immediate checks evaluated whenever the combinational logic settles. They take for granted that the inputs hold still between evaluations and that DATA_W is a power of two, so that the final funnel stage moves a whole word. Because of that, the bench changes inputs only on the falling clock edge and compares at the following rising edge, after everything has settled. The stimulus covers all eight kind codes and every count up to the widest value the port can carry. Counts above 32 and the three unused kind codes are driven deliberately, so that the saturation rule and the pass-through rule are checked as well.

// File: rtl/shf_pkg.sv
package shf_pkg;

  // Shift kind encoding seen on the i_kind port
  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_LSR = 3'd1,
    SK_ASR = 3'd2,
    SK_ROR = 3'd3,
    SK_RRX = 3'd4
  } shift_kind_e;

  function automatic logic kind_is_legal(input logic [2:0] k);
    return (k <= 3'd4);
  endfunction

  function automatic logic kind_uses_count(input logic [2:0] k);
    return (k <= 3'd3);
  endfunction

endpackage

// File: rtl/shf_amount_norm.sv
module shf_amount_norm
  import shf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W) + 1
) (
  input  logic [2:0]       kind,
  input  logic [AMT_W-1:0] amount,
  output logic [AMT_W-1:0] eff,
  output logic             kind_ok
);

  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

  // Clamp the requested count to a whole word; the carry rotate always moves by one
  always_comb begin
    kind_ok = kind_is_legal(kind);
    eff     = '0;
    if (kind == SK_RRX)
      eff = AMT_W'(1);
    else if (kind_uses_count(kind))
      eff = (amount > FULL) ? FULL : amount;
  end

  always_comb begin
    p_eff_range_r8: assert (eff <= FULL)
      else $error("effective count exceeds word width");
    if (kind_uses_count(kind) && amount > FULL)
      p_sat_full_r8: assert (eff == FULL)
        else $error("oversized count not saturated");
    if (!kind_ok)
      p_undef_still_r9: assert (eff == '0)
        else $error("unused kind produced motion");
  end

endmodule

// File: rtl/shf_funnel.sv
module shf_funnel #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] lo_word,
  input  logic [DATA_W-1:0] fill_word,
  input  logic [AMT_W-1:0]  n,
  output logic [DATA_W-1:0] out_word
);

  localparam int STG = AMT_W;

  // Pair of words {hi, lo} moved right stage by stage; the low word is the answer
  logic [DATA_W-1:0] lo_st [0:STG];
  logic [DATA_W-1:0] hi_st [0:STG-1];

  assign lo_st[0] = lo_word;
  assign hi_st[0] = fill_word;

  for (genvar i = 0; i < STG; i++) begin : g_stage
    if (i == STG - 1) begin : g_last
      // The widest stage moves a whole word: the fill word replaces the low word
      assign lo_st[i+1] = n[i] ? hi_st[i] : lo_st[i];
    end else begin : g_mid
      logic [2*DATA_W-1:0] moved;
      assign moved      = {hi_st[i], lo_st[i]} >> (1 << i);
      assign lo_st[i+1] = n[i] ? moved[DATA_W-1:0]        : lo_st[i];
      assign hi_st[i+1] = n[i] ? moved[2*DATA_W-1:DATA_W] : hi_st[i];
    end
  end

  assign out_word = lo_st[STG];

  always_comb begin
    if (n == '0)
      p_idle_pass_r6: assert (out_word == lo_word)
        else $error("funnel altered word at zero count");
  end

endmodule

// File: rtl/shf_carry_pick.sv
module shf_carry_pick #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] word,
  input  logic [AMT_W-1:0]  n,
  output logic              bit_out,
  output logic              moved
);

  // Bit n-1 of the word is the last to leave a right move by n
  function automatic logic last_out(input logic [DATA_W-1:0] w, input logic [AMT_W-1:0] cnt);
    logic b;
    b = 1'b0;
    for (int k = 0; k < DATA_W; k++)
      if (int'(cnt) == k + 1) b = w[k];
    return b;
  endfunction

  assign bit_out = last_out(word, n);
  assign moved   = (n != '0);

endmodule

// File: rtl/barrel_shift_carry.sv
module barrel_shift_carry
  import shf_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] i_operand,
  input  logic [2:0]        i_kind,
  input  logic [AMT_W-1:0]  i_amount,
  input  logic              i_carry,
  output logic [DATA_W-1:0] o_result,
  output logic              o_carry
);

  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

  function automatic logic [DATA_W-1:0] flip(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int k = 0; k < DATA_W; k++) r[k] = v[DATA_W-1-k];
    return r;
  endfunction

  shift_kind_e       kind;
  logic [AMT_W-1:0]  eff_n;
  logic              kind_ok;
  logic              is_left;
  logic [DATA_W-1:0] src_word;
  logic [DATA_W-1:0] fill_word;
  logic [DATA_W-1:0] funnel_out;
  logic              picked_bit;
  logic              any_moved;

  assign kind = shift_kind_e'(i_kind);

  shf_amount_norm #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_norm (
    .kind    (i_kind),
    .amount  (i_amount),
    .eff     (eff_n),
    .kind_ok (kind_ok)
  );

  // Left shifts run through the right funnel on a bit-reversed word
  assign is_left  = (kind == SK_LSL);
  assign src_word = is_left ? flip(i_operand) : i_operand;

  always_comb begin
    unique case (kind)
      SK_ASR:  fill_word = {DATA_W{i_operand[DATA_W-1]}};
      SK_ROR:  fill_word = i_operand;
      SK_RRX:  fill_word = {DATA_W{i_carry}};
      default: fill_word = '0;
    endcase
  end

  shf_funnel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_funnel (
    .lo_word   (src_word),
    .fill_word (fill_word),
    .n         (eff_n),
    .out_word  (funnel_out)
  );

  shf_carry_pick #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_pick (
    .word    (src_word),
    .n       (eff_n),
    .bit_out (picked_bit),
    .moved   (any_moved)
  );

  always_comb begin
    if (!kind_ok)     o_result = i_operand;
    else if (is_left) o_result = flip(funnel_out);
    else              o_result = funnel_out;
  end

  assign o_carry = any_moved ? picked_bit : i_carry;

  // Checks on the port relationships, evaluated as the logic settles
  always_comb begin
    if (kind == SK_LSL && i_amount != '0)
      p_low_zero_r1: assert (o_result[0] == 1'b0)
        else $error("left shift left a one in bit 0");
    if (kind == SK_LSR && i_amount != '0)
      p_top_zero_r2: assert (o_result[DATA_W-1] == 1'b0)
        else $error("logical right shift kept a one on top");
    if (kind == SK_ASR)
      p_sign_kept_r3: assert (o_result[DATA_W-1] == i_operand[DATA_W-1])
        else $error("arithmetic shift lost the sign");
    if (kind == SK_ROR && i_amount != '0)
      p_ror_carry_r4: assert (o_carry == o_result[DATA_W-1])
        else $error("rotate carry differs from bit 31");
    if (kind == SK_RRX)
      p_rrx_path_r5: assert (o_carry == i_operand[0] && o_result[DATA_W-1] == i_carry)
        else $error("carry rotate path broken");
    if (kind_uses_count(i_kind) && i_amount == '0)
      p_zero_count_r6: assert (o_result == i_operand && o_carry == i_carry)
        else $error("zero count changed state");
    if (kind == SK_LSR && i_amount >= FULL)
      p_lsr_full_r7: assert (o_result == '0 && o_carry == i_operand[DATA_W-1])
        else $error("full logical right shift wrong");
    if (!kind_is_legal(i_kind))
      p_unused_kind_r9: assert (o_result == i_operand && o_carry == i_carry)
        else $error("unused kind not passed through");
  end

endmodule

// File: tb/tb_barrel_shift_carry.sv
module tb_barrel_shift_carry;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic [W-1:0] op  = '0;
  logic [2:0]   kd  = '0;
  logic [5:0]   amt = '0;
  logic         cin = 1'b0;
  logic [W-1:0] res;
  logic         cout;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  barrel_shift_carry dut (
    .i_operand (op),
    .i_kind    (kd),
    .i_amount  (amt),
    .i_carry   (cin),
    .o_result  (res),
    .o_carry   (cout)
  );

  // One-position-at-a-time model of every shift kind
  task automatic model(input logic [W-1:0] a, input logic [2:0] k, input logic [5:0] n_in,
                       input logic c_in, output logic [W-1:0] r, output logic c);
    int n;
    r = a;
    c = c_in;
    if (k > 3'd4) return;
    n = (k == 3'd4) ? 1 : ((n_in > 6'd32) ? 32 : int'(n_in));
    for (int s = 0; s < n; s++) begin
      case (k)
        3'd0: begin c = r[W-1]; r = r << 1; end
        3'd1: begin c = r[0];   r = r >> 1; end
        3'd2: begin c = r[0];   r = {r[W-1], r[W-1:1]}; end
        3'd3: begin c = r[0];   r = {r[0], r[W-1:1]}; end
        default: begin c = r[0]; r = {c_in, r[W-1:1]}; end
      endcase
    end
  endtask

  function automatic string tag(input logic [2:0] k, input logic [5:0] n);
    if (k > 3'd4) return "R9";
    if (k == 3'd4) return "R5";
    if (n == 6'd0) return "R6";
    if (n > 6'd32) return "R8";
    if (n == 6'd32) return "R7";
    case (k)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic compare(input string req);
    logic [W-1:0] er;
    logic ec;
    model(op, kd, amt, cin, er, ec);
    checks++;
    if (res !== er || cout !== ec) begin
      errors++;
      $display("FAIL %s: op=%h kind=%0d amt=%0d cin=%0b got res=%h c=%0b expected res=%h c=%0b",
               req, op, kd, amt, cin, res, cout, er, ec);
    end
  endtask

  task automatic run_vec(input logic [W-1:0] a, input logic [2:0] k, input logic [5:0] n,
                         input logic c);
    @(negedge clk);
    op = a; kd = k; amt = n; cin = c;
    @(posedge clk);
    compare(tag(k, n));
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    // Idle inputs: all-zero word, left shift by zero, carry clear (R6)
    @(posedge clk);
    compare("R6");
    // R1: left shifts, including the top carry position
    run_vec(32'h8000_0001, 3'd0, 6'd1, 1'b0);
    run_vec(32'h0001_0000, 3'd0, 6'd16, 1'b0);
    run_vec(32'hFFFF_FFFF, 3'd0, 6'd31, 1'b0);
    // R2 / R3: right shifts on signed and unsigned patterns
    run_vec(32'h8000_0000, 3'd1, 6'd31, 1'b1);
    run_vec(32'hF000_000F, 3'd1, 6'd4, 1'b0);
    run_vec(32'h8000_0000, 3'd2, 6'd31, 1'b0);
    run_vec(32'h7FFF_FFF0, 3'd2, 6'd5, 1'b1);
    // R4: rotations
    run_vec(32'h0000_0001, 3'd3, 6'd1, 1'b0);
    run_vec(32'h1234_5678, 3'd3, 6'd8, 1'b1);
    // R5: carry rotate ignores the count
    run_vec(32'h0000_0003, 3'd4, 6'd0, 1'b1);
    run_vec(32'hAAAA_AAAA, 3'd4, 6'd47, 1'b0);
    // R6: zero count for each counted kind
    for (int k = 0; k < 4; k++) run_vec(32'hDEAD_BEEF, 3'(k), 6'd0, 1'b1);
    // R7: full-word counts
    for (int k = 0; k < 4; k++) run_vec(32'h8000_0001, 3'(k), 6'd32, 1'b0);
    for (int k = 0; k < 4; k++) run_vec(32'h7FFF_FFFE, 3'(k), 6'd32, 1'b1);
    // R8: oversized counts
    for (int k = 0; k < 4; k++) run_vec(32'hC000_0003, 3'(k), 6'd63, 1'b0);
    for (int k = 0; k < 4; k++) run_vec(32'h4000_0002, 3'(k), 6'd33, 1'b1);
    // R9: unused kind codes
    for (int k = 5; k < 8; k++) run_vec(32'h0F0F_00FF, 3'(k), 6'd7, 1'b1);
    // Every kind against every count on varied words
    for (int k = 0; k < 8; k++)
      for (int n = 0; n < 64; n++) begin
        seed = next_rand(seed);
        run_vec(seed, 3'(k), 6'(n), seed[7]);
      end
    for (int i = 0; i < 1500; i++) begin
      seed = next_rand(seed);
      run_vec(seed, seed[2:0], seed[13:8], seed[20]);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule